// File: doc/BRIEF.md
# Serial Configuration Memory Read Responder

This block plays the memory side of a serial configuration-memory link that a host drives purely by register writes. The host owns a control register holding a select line, a clock line and two spare host lines, plus a one-bit data register. Raising select arms the responder. A rising edge on the software-toggled clock bit then acts as a start bit. The next eight clock edges sample the data register into a command byte.

When the command's top bit is set, the low seven bits name a 16-bit word. The responder fetches two bytes from its internal byte array, the even byte as the high half and the following odd byte as the low half. It then presents the word one bit per clock edge, most significant bit first, on the data register.

Any other command is flagged as an error and the responder goes idle. Reading past the sixteenth bit is flagged as an overrun. A write that sets undefined register bits is refused. The byte array is filled through a separate load port.

Top module: `sprom_responder`

## Requirements
- R1: After reset the state output is idle, both registers read 0 and all three error outputs are 0. The state codes are 0 idle, 1 ready, 2 command and 3 read.
- R2: An accepted control write with select (bit 1) equal to 0 forces idle from any state. A control write that takes select from 0 to 1 enters ready and clears the command-error and overrun flags.
- R3: Only an accepted control write that takes the clock bit (bit 0) from 0 to 1, relative to the stored control value, advances the protocol. Rewriting clock as 1 leaves the state and the bit count unchanged.
- R4: In ready, a rising clock edge is taken as the start bit and moves the block to the command state with its bit count cleared.
- R5: In the command state, each rising clock edge shifts data-register bit 0 into the command LSB. After the eighth edge the command is decoded.
- R6: A command with bit 7 set enters the read state with word {mem[2*c], mem[2*c+1]}, where c is command bits 6..0. Each later rising clock edge writes the word's current MSB into data-register bit 0, visible on the next cycle, and shifts the word left by one.
- R7: A command with bit 7 clear sets the sticky err_cmd output and returns the block to idle.
- R8: The 17th and later rising clock edges in the read state drive data bit 0 as 0. They also set the sticky err_overrun output, which holds until select rises again.
- R9: A control write with any of bits 7..4 set, or a data write with any of bits 7..1 set, changes neither register nor the state. err_reject is 1 for the one cycle after it.
- R10: rd_sel 0 returns the control register and rd_sel 1 the data register. Control bits 3..2 are stored and read back but do not affect the protocol.
- R11: A mem_we pulse stores mem_wdata at mem_addr in the byte array that read commands fetch from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 data |
| wr_data | input | 8 | Register write value |
| rd_sel | input | 1 | Read source: 0 control, 1 data |
| rd_data | output | 8 | Selected register value |
| mem_we | input | 1 | Byte array load strobe |
| mem_addr | input | 8 | Byte array load address |
| mem_wdata | input | 8 | Byte array load value |
| state_o | output | 2 | Protocol state code |
| err_cmd | output | 1 | Sticky non-read command flag |
| err_overrun | output | 1 | Sticky read overrun flag |
| err_reject | output | 1 | One-cycle refused-write flag |

## Verification
Reads are issued to the first word, to a word whose command bits are asymmetric, and to the last word of the array. Between them these catch a reversed command shift order, swapped byte halves and a lost top address bit. Words of all ones, all zeros and alternating bits separate a stuck data bit from a wrong shift direction. Repeated clock-high writes inside a command show whether the block reacts to levels rather than edges. A non-read command, a select drop mid-command, a 17th read edge and refused writes each check one exit path and its flag against the register readback.

// File: rtl/sprom_pkg.sv
package sprom_pkg;
  localparam int CMD_W  = 8;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int MEM_AW = CMD_W;

  localparam int CB_CLK = 0;
  localparam int CB_SEL = 1;
  localparam logic [BYTE_W-1:0] CTRL_MASK = 8'h0F;
  localparam logic [BYTE_W-1:0] DATA_MASK = 8'h01;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READY = 2'd1,
    ST_CMD   = 2'd2,
    ST_READ  = 2'd3
  } st_t;

  function automatic logic [MEM_AW-1:0] word_base(input logic [CMD_W-1:0] c);
    return {c[CMD_W-2:0], 1'b0};
  endfunction

  function automatic logic cmd_is_read(input logic [CMD_W-1:0] c);
    return c[CMD_W-1];
  endfunction

  function automatic logic rose(input logic old_v, input logic new_v);
    return !old_v && new_v;
  endfunction

  function automatic logic fits(input logic [BYTE_W-1:0] v, input logic [BYTE_W-1:0] m);
    return (v & ~m) == '0;
  endfunction
endpackage

// File: rtl/sprom_store.sv
module sprom_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rd_hi,
  output logic [DW-1:0] rd_lo
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] raddr_lo;

  assign raddr_lo = raddr + AW'(1);

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd_hi = mem[raddr];
  assign rd_lo = mem[raddr_lo];
endmodule

// File: rtl/sprom_regs.sv
module sprom_regs
  import sprom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              drv_we,
  input  logic              drv_bit,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] data_q,
  output logic              ev_sel_drop,
  output logic              ev_sel_rise,
  output logic              ev_clk_rise,
  output logic              ev_reject,
  output logic              err_reject
);
  logic ok, ctrl_acc, data_acc;

  assign ok       = wr_sel ? fits(wr_data, DATA_MASK) : fits(wr_data, CTRL_MASK);
  assign ctrl_acc = wr_en && !wr_sel && ok;
  assign data_acc = wr_en &&  wr_sel && ok;
  assign ev_reject = wr_en && !ok;

  assign ev_sel_drop = ctrl_acc && !wr_data[CB_SEL];
  assign ev_sel_rise = ctrl_acc && rose(ctrl_q[CB_SEL], wr_data[CB_SEL]);
  assign ev_clk_rise = ctrl_acc && rose(ctrl_q[CB_CLK], wr_data[CB_CLK]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      data_q     <= '0;
      err_reject <= 1'b0;
    end else begin
      err_reject <= ev_reject;
      if (ctrl_acc) ctrl_q <= wr_data;
      if (data_acc)    data_q <= wr_data;
      else if (drv_we) data_q <= {{(BYTE_W-1){1'b0}}, drv_bit};
    end
  end
endmodule

// File: rtl/sprom_fsm.sv
module sprom_fsm
  import sprom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_sel_drop,
  input  logic              ev_sel_rise,
  input  logic              ev_clk_rise,
  input  logic              din,
  input  logic [BYTE_W-1:0] mem_hi,
  input  logic [BYTE_W-1:0] mem_lo,
  output logic [MEM_AW-1:0] fetch_addr,
  output st_t               state,
  output logic              drv_we,
  output logic              drv_bit,
  output logic              ev_cmd_done,
  output logic              ev_bad_cmd,
  output logic              err_cmd,
  output logic              err_overrun
);
  localparam int CNT_W = $clog2(WORD_W + 2) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  st_t               eff, nxt;
  logic [CMD_W-1:0]  cmd_q, cmd_nx;
  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  cnt_q, cnt_inc;
  logic              shift_cmd, shift_out, ovr_hit;

  always_comb begin
    if (ev_sel_drop)      eff = ST_IDLE;
    else if (ev_sel_rise) eff = ST_READY;
    else                  eff = state;
  end

  assign cnt_inc    = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);
  assign cmd_nx     = {cmd_q[CMD_W-2:0], din};
  assign fetch_addr = word_base(cmd_nx);

  assign shift_cmd   = ev_clk_rise && (eff == ST_CMD);
  assign shift_out   = ev_clk_rise && (eff == ST_READ);
  assign ev_cmd_done = shift_cmd && (cnt_inc == CNT_W'(CMD_W));
  assign ev_bad_cmd  = ev_cmd_done && !cmd_is_read(cmd_nx);
  assign ovr_hit     = shift_out && (cnt_inc > CNT_W'(WORD_W));

  assign drv_we  = shift_out;
  assign drv_bit = word_q[WORD_W-1];

  always_comb begin
    nxt = eff;
    if (ev_clk_rise) begin
      case (eff)
        ST_READY: nxt = ST_CMD;
        ST_CMD:   if (ev_cmd_done) nxt = cmd_is_read(cmd_nx) ? ST_READ : ST_IDLE;
        default:  nxt = eff;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cmd_q       <= '0;
      word_q      <= '0;
      cnt_q       <= '0;
      err_cmd     <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      state <= nxt;
      if (ev_sel_rise) begin
        err_cmd     <= 1'b0;
        err_overrun <= 1'b0;
      end
      if (ev_clk_rise && eff == ST_READY) begin
        cnt_q <= '0;
      end else if (shift_cmd) begin
        cmd_q <= cmd_nx;
        if (ev_cmd_done) begin
          cnt_q  <= '0;
          word_q <= {mem_hi, mem_lo};
          if (!cmd_is_read(cmd_nx)) err_cmd <= 1'b1;
        end else begin
          cnt_q <= cnt_inc;
        end
      end else if (shift_out) begin
        word_q <= {word_q[WORD_W-2:0], 1'b0};
        cnt_q  <= cnt_inc;
        if (ovr_hit) err_overrun <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sprom_responder.sv
module sprom_responder
  import sprom_pkg::*;
#(
  parameter int DATA_W = BYTE_W,
  parameter int ADDR_W = MEM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic [1:0]        state_o,
  output logic              err_cmd,
  output logic              err_overrun,
  output logic              err_reject
);
  logic [BYTE_W-1:0] ctrl_q, data_q, mem_hi, mem_lo;
  logic [MEM_AW-1:0] fetch_addr;
  logic ev_sel_drop, ev_sel_rise, ev_clk_rise, ev_reject;
  logic ev_cmd_done, ev_bad_cmd, drv_we, drv_bit;
  st_t  state;

  sprom_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .drv_we(drv_we), .drv_bit(drv_bit), .ctrl_q(ctrl_q), .data_q(data_q),
    .ev_sel_drop(ev_sel_drop), .ev_sel_rise(ev_sel_rise), .ev_clk_rise(ev_clk_rise),
    .ev_reject(ev_reject), .err_reject(err_reject)
  );

  sprom_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ev_sel_drop(ev_sel_drop), .ev_sel_rise(ev_sel_rise),
    .ev_clk_rise(ev_clk_rise), .din(data_q[0]), .mem_hi(mem_hi), .mem_lo(mem_lo),
    .fetch_addr(fetch_addr), .state(state), .drv_we(drv_we), .drv_bit(drv_bit),
    .ev_cmd_done(ev_cmd_done), .ev_bad_cmd(ev_bad_cmd),
    .err_cmd(err_cmd), .err_overrun(err_overrun)
  );

  sprom_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr(fetch_addr), .rd_hi(mem_hi), .rd_lo(mem_lo)
  );

  assign rd_data = rd_sel ? data_q : ctrl_q;
  assign state_o = state;
endmodule

// File: rtl/sprom_responder_chk.sv
module sprom_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] state_o,
  input logic [7:0] ctrl_q,
  input logic [7:0] data_q,
  input logic       ev_sel_drop,
  input logic       ev_sel_rise,
  input logic       ev_clk_rise,
  input logic       ev_reject,
  input logic       ev_bad_cmd,
  input logic       err_cmd,
  input logic       err_overrun,
  input logic       err_reject
);
  p_drop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sel_drop |=> state_o == 2'd0);

  p_rise_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sel_rise && !ev_clk_rise) |=> (state_o == 2'd1 && !err_cmd && !err_overrun));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_clk_rise && !ev_sel_drop && !ev_sel_rise) |=> $stable(state_o));

  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clk_rise && !ev_sel_drop && !ev_sel_rise && state_o == 2'd1) |=> state_o == 2'd2);

  p_bad_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_cmd |=> (err_cmd && state_o == 2'd0));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cmd && !ev_sel_rise) |=> err_cmd);

  p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> ($past(state_o) == 2'd3 && data_q[0] == 1'b0));

  p_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> (err_reject && $stable(ctrl_q) && $stable(data_q)));
endmodule

bind sprom_responder sprom_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state_o(state_o), .ctrl_q(ctrl_q), .data_q(data_q),
  .ev_sel_drop(ev_sel_drop), .ev_sel_rise(ev_sel_rise), .ev_clk_rise(ev_clk_rise),
  .ev_reject(ev_reject), .ev_bad_cmd(ev_bad_cmd), .err_cmd(err_cmd),
  .err_overrun(err_overrun), .err_reject(err_reject)
);

// File: tb/sim_sprom_responder.sv
module sim_sprom_responder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, mem_we = 1'b0;
  logic [7:0] wr_data = '0, mem_addr = '0, mem_wdata = '0, rd_data;
  logic [1:0] state_o;
  logic       err_cmd, err_overrun, err_reject;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model [256];

  always #5 clk = ~clk;

  sprom_responder u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .state_o(state_o), .err_cmd(err_cmd),
    .err_overrun(err_overrun), .err_reject(err_reject)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] v);
    rd_sel = s; #1; v = rd_data;
  endtask

  task automatic mload(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); mem_we = 1'b1; mem_addr = a; mem_wdata = v;
    @(negedge clk); mem_we = 1'b0;
    model[a] = v;
  endtask

  task automatic begin_cmd();
    wr(0, 8'h00); wr(0, 8'h02); wr(0, 8'h03);
  endtask

  task automatic cmd_bits(input logic [7:0] c);
    for (int i = 7; i >= 0; i--) begin
      wr(1, {7'd0, c[i]}); wr(0, 8'h02); wr(0, 8'h03);
    end
  endtask

  task automatic read_word(output logic [15:0] w);
    logic [7:0] v;
    w = '0;
    for (int i = 0; i < 16; i++) begin
      wr(0, 8'h02); wr(0, 8'h03);
      rd(1, v);
      w = {w[14:0], v[0]};
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 state", state_o, 0);
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 data", v, 0);
    chk("R1 flags", {err_cmd, err_overrun, err_reject}, 0);
  endtask

  task automatic t_read(input logic [6:0] c);
    logic [15:0] w;
    logic [7:0]  b;
    begin_cmd();
    chk("R4 start", state_o, 2);
    cmd_bits({1'b1, c});
    chk("R6 read state", state_o, 3);
    read_word(w);
    b = {c, 1'b0};
    chk("R5 R6 R11 word", w, {model[b], model[b + 8'd1]});
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    chk("R8 clear before", err_overrun, 0);
    wr(0, 8'h02); wr(0, 8'h03);
    rd(1, v);
    chk("R8 bit 17 zero", v, 0);
    chk("R8 overrun", err_overrun, 1);
    wr(0, 8'h02); wr(0, 8'h03);
    chk("R8 sticky", err_overrun, 1);
    wr(0, 8'h00); wr(0, 8'h02);
    chk("R2 overrun cleared", err_overrun, 0);
    chk("R2 ready", state_o, 1);
  endtask

  task automatic t_bad_cmd();
    begin_cmd();
    cmd_bits(8'h25);
    chk("R7 err_cmd", err_cmd, 1);
    chk("R7 idle", state_o, 0);
    wr(0, 8'h02); wr(0, 8'h03);
    chk("R7 still idle", state_o, 0);
    chk("R7 sticky", err_cmd, 1);
    wr(0, 8'h00); wr(0, 8'h02);
    chk("R2 err_cmd cleared", err_cmd, 0);
  endtask

  task automatic t_sel_drop();
    begin_cmd();
    for (int i = 0; i < 3; i++) begin
      wr(1, 8'h01); wr(0, 8'h02); wr(0, 8'h03);
    end
    wr(0, 8'h01);
    chk("R2 drop idle", state_o, 0);
  endtask

  task automatic t_level();
    logic [15:0] w;
    logic [7:0]  c;
    c = 8'hC3;
    begin_cmd();
    wr(0, 8'h03);
    for (int i = 7; i >= 0; i--) begin
      wr(1, {7'd0, c[i]}); wr(0, 8'h02); wr(0, 8'h03); wr(0, 8'h03);
      if (i == 1) chk("R3 seven edges", state_o, 2);
    end
    chk("R3 eight edges", state_o, 3);
    read_word(w);
    chk("R3 word", w, {model[8'h86], model[8'h87]});
  endtask

  task automatic t_reject();
    logic [7:0] v;
    wr(0, 8'h00); wr(0, 8'h02);
    wr(0, 8'h13);
    chk("R9 pulse", err_reject, 1);
    rd(0, v); chk("R9 ctrl kept", v, 8'h02);
    chk("R9 state kept", state_o, 1);
    @(negedge clk);
    chk("R9 pulse ends", err_reject, 0);
    wr(1, 8'h01);
    wr(1, 8'h02);
    chk("R9 data pulse", err_reject, 1);
    rd(1, v); chk("R9 data kept", v, 8'h01);
  endtask

  task automatic t_readback();
    logic [7:0] v;
    wr(0, 8'h0C);
    rd(0, v); chk("R10 ctrl spare", v, 8'h0C);
    chk("R10 no effect", state_o, 0);
    wr(0, 8'h0E);
    rd(0, v); chk("R10 ctrl readback", v, 8'h0E);
    chk("R10 select seen", state_o, 1);
    wr(1, 8'h00);
    rd(1, v); chk("R10 data readback", v, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    for (int i = 0; i < 256; i++) mload(8'(i), 8'((i * 37 + 11) ^ (i >> 3)));
    mload(8'h0A, 8'hFF); mload(8'h0B, 8'hFF);
    mload(8'h20, 8'h00); mload(8'h21, 8'h00);
    mload(8'h00, 8'hA5); mload(8'h01, 8'h5A);
    t_read(7'h00);
    t_read(7'h05);
    t_read(7'h10);
    t_read(7'h0B);
    t_read(7'h7F);
    t_overrun();
    t_bad_cmd();
    t_sel_drop();
    t_level();
    t_reject();
    t_readback();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule